// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block decides when the processor leaves its normal flow for an exception and carries out the switch in a single clock cycle. Seven exception sources can raise a request: reset, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt and fast interrupt. When one is accepted, the block does several things at once:

- It copies the live status word into the saved-status register of the mode being entered.
- It rewrites the mode field and the interrupt-disable bits.
- It writes a return address into that mode's link register.
- It hands a fixed vector address to the fetch unit with a one-cycle load strobe.

One cycle later a one-cycle flush pulse tells the three-stage pipeline to discard what it had fetched. A return request runs the reverse path. The status word comes back from the current mode's saved copy, and the program counter is loaded from the current mode's link register.

The return address is derived from `pcNow`. This is the fetch-side program counter, which is 8 bytes ahead of the instruction in the execute stage. The block holds the live status word, five banked saved-status registers and five banked link registers. A write port lets the surrounding core overwrite the status word directly.

Top module: `trap_sequencer`

## Requirements
- R1: While `rstN` is low, and directly after it rises:
  - `status` is 0x000000D3 (supervisor mode 5'b10011, I bit 7 set, F bit 6 set).
  - All saved-status and link registers are zero.
  - `pcOut` is zero.
  - `pcLoad` and `flush` are low.
- R2: An accepted entry loads `pcOut` with the vector VEC_BASE + 4*k and raises `pcLoad` in the next cycle. The codes k are: reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, normal interrupt 6, fast interrupt 7. Code 5 is unused.
- R3: Entry writes the target mode into `status[4:0]`:
  - Reset and software interrupt enter supervisor mode (10011).
  - Both aborts enter abort mode (10111).
  - Undefined instruction enters undefined mode (11011).
  - Normal interrupt enters interrupt mode (10010).
  - Fast interrupt enters fast mode (10001).
- R4: When several requests are present in one cycle, exactly one is accepted, in this order of precedence:
  1. reset
  2. data abort
  3. fast interrupt
  4. normal interrupt
  5. prefetch abort
  6. undefined instruction
  7. software interrupt
- R5: Every entry sets the I bit. Reset and fast-interrupt entry also set the F bit. No other status bit changes on entry.
- R6: A normal-interrupt request is ignored while I is set, and a fast-interrupt request is ignored while F is set.
- R7: Every entry except reset does two writes into the target mode's bank:
  - The saved-status register receives the status word as it was before the entry.
  - The link register receives a return address that depends on the exception:

    | Exception | Link value |
    |---|---|
    | undefined instruction, software interrupt, prefetch abort | `pcNow`-4 |
    | normal interrupt, fast interrupt, data abort | `pcNow` |

  Reset entry writes neither register.
- R8: `pcLoad` is high for exactly the cycle after an entry or return is accepted, and `flush` is high for exactly the cycle after that. Requests and returns presented while `pcLoad` or `flush` is high are ignored.
- R9: A return accepted in a mode that has a bank (fast, interrupt, supervisor, abort or undefined) loads `status` from that bank's saved-status register and `pcOut` from its link register. A return in user (10000) or system (11111) mode is ignored. Any accepted entry takes precedence over a return.
- R10: `statusWr` loads `statusIn` into the status word on any edge at which no entry or return is accepted.
- R11: `savedOut` and `linkOut` show the saved-status and link registers of the bank selected by the current mode. Both read zero in user and system mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rstReq | input | 1 | Reset exception request |
| undefReq | input | 1 | Undefined-instruction request |
| swiReq | input | 1 | Software-interrupt request |
| pabtReq | input | 1 | Prefetch-abort request |
| dabtReq | input | 1 | Data-abort request |
| irqReq | input | 1 | Normal interrupt request |
| fiqReq | input | 1 | Fast interrupt request |
| retReq | input | 1 | Exception return request |
| pcNow | input | XLEN | Fetch-side program counter (execute address + 8) |
| statusWr | input | 1 | Direct status-word write strobe |
| statusIn | input | 32 | Value for a direct status write |
| status | output | 32 | Live status word |
| savedOut | output | 32 | Saved-status register of the current mode |
| linkOut | output | XLEN | Link register of the current mode |
| pcOut | output | XLEN | Address to load into the program counter |
| pcLoad | output | 1 | One-cycle strobe qualifying `pcOut` |
| flush | output | 1 | One-cycle pipeline flush pulse |

## Verification
The embedded assertions watch, on every cycle, the handshake that no bench scenario can fully enumerate:
- a load strobe is always followed by a single flush pulse;
- nothing is accepted while either pulse is high;
- a masked interrupt is never chosen;
- every entry leaves the I bit set, a privileged target mode and an aligned in-range vector;
- a return restores exactly the saved word that was visible before it.

The precedence among simultaneous requests, the exact return-address offset for each exception, the untouched reset bank and the ignored return from user mode are visible only in the values the bench's model predicts. The bench compares those values cycle by cycle under directed and random stimulus.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int STAT_W     = 32;
  localparam int MODE_W     = 5;
  localparam int BANKS      = 5;
  localparam int BANK_IDX_W = $clog2(BANKS);
  localparam int KIND_W     = 3;
  localparam int NUM_KINDS  = 7;
  localparam int I_BIT      = 7;
  localparam int F_BIT      = 6;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  // Code doubles as vector slot index.
  typedef enum logic [KIND_W-1:0] {
    KIND_RESET = 3'd0,
    KIND_UNDEF = 3'd1,
    KIND_SWI   = 3'd2,
    KIND_PABT  = 3'd3,
    KIND_DABT  = 3'd4,
    KIND_IRQ   = 3'd6,
    KIND_FIQ   = 3'd7
  } kind_e;

  typedef struct packed {
    logic  enter;
    logic  leave;
    kind_e kind;
  } seqCmd_t;

  localparam logic [STAT_W-1:0] RESET_STATUS =
    STAT_W'({1'b1, 1'b1, 1'b0, MODE_SVC});

  function automatic mode_e modeOf(kind_e k);
    case (k)
      KIND_UNDEF:             return MODE_UND;
      KIND_PABT, KIND_DABT:   return MODE_ABT;
      KIND_IRQ:               return MODE_IRQ;
      KIND_FIQ:               return MODE_FIQ;
      default:                return MODE_SVC;
    endcase
  endfunction

  // Returns {bank present, bank index}.
  function automatic logic [BANK_IDX_W:0] bankOf(logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: return {1'b1, BANK_IDX_W'(0)};
      MODE_IRQ: return {1'b1, BANK_IDX_W'(1)};
      MODE_SVC: return {1'b1, BANK_IDX_W'(2)};
      MODE_ABT: return {1'b1, BANK_IDX_W'(3)};
      MODE_UND: return {1'b1, BANK_IDX_W'(4)};
      default:  return {1'b0, BANK_IDX_W'(0)};
    endcase
  endfunction
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rstReq,
  input  logic              undefReq,
  input  logic              swiReq,
  input  logic              pabtReq,
  input  logic              dabtReq,
  input  logic              irqReq,
  input  logic              fiqReq,
  input  logic              retReq,
  input  logic [MODE_W-1:0] curMode,
  input  logic              iMask,
  input  logic              fMask,
  output seqCmd_t           cmd,
  output logic              pcLoad,
  output logic              flush
);
  // Highest precedence first.
  localparam kind_e PRIO [NUM_KINDS] = '{KIND_RESET, KIND_DABT, KIND_FIQ,
                                         KIND_IRQ, KIND_PABT, KIND_UNDEF, KIND_SWI};

  logic [7:0]            reqVec;
  logic [7:0]            eligible;
  logic                  busy;
  logic [BANK_IDX_W:0]   curBank;

  assign reqVec   = {fiqReq, irqReq, 1'b0, dabtReq, pabtReq, swiReq, undefReq, rstReq};
  assign eligible = reqVec & ~{fMask, iMask, 6'b0};
  assign busy     = pcLoad | flush;
  assign curBank  = bankOf(curMode);

  always_comb begin
    cmd = '0;
    for (int p = NUM_KINDS - 1; p >= 0; p--) begin
      if (eligible[PRIO[p]]) begin
        cmd.enter = 1'b1;
        cmd.kind  = PRIO[p];
      end
    end
    if (busy) cmd.enter = 1'b0;
    cmd.leave = !busy && !cmd.enter && retReq && curBank[BANK_IDX_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcLoad <= 1'b0;
      flush  <= 1'b0;
    end else begin
      pcLoad <= cmd.enter | cmd.leave;
      flush  <= pcLoad;
    end
  end

  AST_FLUSH_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> flush); // R8
  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !flush); // R8
  AST_IDLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad || flush) |-> !(cmd.enter || cmd.leave)); // R8
  AST_IRQ_MASK_HONOURED: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.enter && (cmd.kind == KIND_IRQ)) |-> !iMask); // R6
  AST_FIQ_MASK_HONOURED: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.enter && (cmd.kind == KIND_FIQ)) |-> !fMask); // R6
endmodule

// File: rtl/trap_dp.sv
module trap_dp
  import trap_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic [XLEN-1:0]   pcNow,
  input  logic              statusWr,
  input  logic [STAT_W-1:0] statusIn,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] savedOut,
  output logic [XLEN-1:0]   linkOut,
  output logic [XLEN-1:0]   pcOut
);
  localparam int SLOT_SHIFT = 2;

  logic [STAT_W-1:0]   statQ;
  logic [STAT_W-1:0]   savedQ [BANKS];
  logic [XLEN-1:0]     linkQ  [BANKS];
  logic [BANK_IDX_W:0] curBank;
  logic [BANK_IDX_W:0] tgtBank;
  logic [STAT_W-1:0]   entryStat;
  logic [XLEN-1:0]     retAddr;
  logic [XLEN-1:0]     vecAddr;
  logic                bankWr;

  // pcNow sits 8 bytes past the instruction in execute.
  function automatic logic [XLEN-1:0] linkFor(kind_e k, logic [XLEN-1:0] pc);
    case (k)
      KIND_UNDEF, KIND_SWI, KIND_PABT: return pc - XLEN'(4);
      default:                         return pc;
    endcase
  endfunction

  assign curBank = bankOf(statQ[MODE_W-1:0]);
  assign tgtBank = bankOf(modeOf(cmd.kind));
  assign retAddr = linkFor(cmd.kind, pcNow);
  assign vecAddr = VEC_BASE + (XLEN'(cmd.kind) << SLOT_SHIFT);
  assign bankWr  = cmd.enter && (cmd.kind != KIND_RESET);

  always_comb begin
    entryStat               = statQ;
    entryStat[MODE_W-1:0]   = modeOf(cmd.kind);
    entryStat[I_BIT]        = 1'b1;
    if (cmd.kind == KIND_RESET || cmd.kind == KIND_FIQ) entryStat[F_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           statQ <= RESET_STATUS;
    else if (cmd.enter)  statQ <= entryStat;
    else if (cmd.leave)  statQ <= savedQ[curBank[BANK_IDX_W-1:0]];
    else if (statusWr)   statQ <= statusIn;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        savedQ[b] <= '0;
        linkQ[b]  <= '0;
      end else if (bankWr && tgtBank[BANK_IDX_W-1:0] == BANK_IDX_W'(b)) begin
        savedQ[b] <= statQ;
        linkQ[b]  <= retAddr;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pcOut <= '0;
    else if (cmd.enter) pcOut <= vecAddr;
    else if (cmd.leave) pcOut <= linkQ[curBank[BANK_IDX_W-1:0]];
  end

  assign status   = statQ;
  assign savedOut = curBank[BANK_IDX_W] ? savedQ[curBank[BANK_IDX_W-1:0]] : '0;
  assign linkOut  = curBank[BANK_IDX_W] ? linkQ[curBank[BANK_IDX_W-1:0]]  : '0;

  AST_ENTRY_SETS_I: assert property (@(posedge clk) disable iff (!rstN)
    cmd.enter |=> status[I_BIT]); // R5
  AST_ENTRY_MODE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.enter |=> status[MODE_W-1:0] == modeOf($past(cmd.kind))); // R3
  AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.enter |=> ((pcOut - VEC_BASE) < XLEN'(32)) && (pcOut[1:0] == 2'b00)); // R2
  AST_RETURN_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    cmd.leave |=> status == $past(savedOut)); // R9
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rstReq,
  input  logic              undefReq,
  input  logic              swiReq,
  input  logic              pabtReq,
  input  logic              dabtReq,
  input  logic              irqReq,
  input  logic              fiqReq,
  input  logic              retReq,
  input  logic [XLEN-1:0]   pcNow,
  input  logic              statusWr,
  input  logic [STAT_W-1:0] statusIn,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] savedOut,
  output logic [XLEN-1:0]   linkOut,
  output logic [XLEN-1:0]   pcOut,
  output logic              pcLoad,
  output logic              flush
);
  seqCmd_t cmd;

  trap_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rstReq   (rstReq),
    .undefReq (undefReq),
    .swiReq   (swiReq),
    .pabtReq  (pabtReq),
    .dabtReq  (dabtReq),
    .irqReq   (irqReq),
    .fiqReq   (fiqReq),
    .retReq   (retReq),
    .curMode  (status[MODE_W-1:0]),
    .iMask    (status[I_BIT]),
    .fMask    (status[F_BIT]),
    .cmd      (cmd),
    .pcLoad   (pcLoad),
    .flush    (flush)
  );

  trap_dp #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .pcNow    (pcNow),
    .statusWr (statusWr),
    .statusIn (statusIn),
    .status   (status),
    .savedOut (savedOut),
    .linkOut  (linkOut),
    .pcOut    (pcOut)
  );
endmodule

// File: tb/test_trap_sequencer.sv
module test_trap_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 4000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        rstReq, undefReq, swiReq, pabtReq, dabtReq, irqReq, fiqReq, retReq;
  logic [31:0] pcNow;
  logic        statusWr;
  logic [31:0] statusIn;
  logic [31:0] status, savedOut, linkOut, pcOut;
  logic        pcLoad, flush;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Model state
  logic [31:0] mStat;
  logic [31:0] mSaved [5];
  logic [31:0] mLink  [5];
  logic [31:0] mPc;
  logic        mPcL, mFl;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_sequencer i_trap_sequencer (
    .clk(clk), .rstN(rstN), .rstReq(rstReq), .undefReq(undefReq), .swiReq(swiReq),
    .pabtReq(pabtReq), .dabtReq(dabtReq), .irqReq(irqReq), .fiqReq(fiqReq),
    .retReq(retReq), .pcNow(pcNow), .statusWr(statusWr), .statusIn(statusIn),
    .status(status), .savedOut(savedOut), .linkOut(linkOut), .pcOut(pcOut),
    .pcLoad(pcLoad), .flush(flush)
  );

  function automatic int bankIdx(logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic logic [4:0] targetMode(int k);
    case (k)
      1:       return 5'b11011;
      3, 4:    return 5'b10111;
      6:       return 5'b10010;
      7:       return 5'b10001;
      default: return 5'b10011;
    endcase
  endfunction

  function automatic logic [31:0] expLink(int k, logic [31:0] pc);
    if (k == 1 || k == 2 || k == 3) return pc - 32'd4;
    return pc;
  endfunction

  function automatic logic [4:0] randMode();
    logic [4:0] modes [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                              5'b10111, 5'b11011, 5'b11111};
    return modes[$urandom_range(0, 6)];
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic compareAll(string tag);
    int b;
    b = bankIdx(mStat[4:0]);
    chk(tag, "status", status, mStat);
    chk(tag, "pcOut", pcOut, mPc);
    chk(tag, "pcLoad", 32'(pcLoad), 32'(mPcL));
    chk(tag, "flush", 32'(flush), 32'(mFl));
    chk(tag, "savedOut", savedOut, (b >= 0) ? mSaved[b] : 32'h0);
    chk(tag, "linkOut", linkOut, (b >= 0) ? mLink[b] : 32'h0);
  endtask

  task automatic modelStep(logic [7:0] req, logic ret, logic wr, logic [31:0] wv,
                           logic [31:0] pc, output string ev);
    int prio [7] = '{0, 4, 7, 6, 3, 1, 2};
    int taken = -1;
    int b;
    logic busy;
    logic nPcL, nFl;
    busy = mPcL || mFl;
    nPcL = 1'b0;
    nFl  = mPcL;
    ev   = "R11";
    if (!busy) begin
      for (int p = 0; p < 7; p++) begin
        int k = prio[p];
        if (taken < 0 && req[k] && !(k == 6 && mStat[7]) && !(k == 7 && mStat[6]))
          taken = k;
      end
    end
    if (taken >= 0) begin
      b = bankIdx(targetMode(taken));
      if (taken != 0) begin
        mSaved[b] = mStat;
        mLink[b]  = expLink(taken, pc);
      end
      mStat[4:0] = targetMode(taken);
      mStat[7]   = 1'b1;
      if (taken == 0 || taken == 7) mStat[6] = 1'b1;
      mPc  = 32'(taken) * 32'd4;
      nPcL = 1'b1;
      ev   = "R5 R7";
    end else if (!busy && ret && bankIdx(mStat[4:0]) >= 0) begin
      b    = bankIdx(mStat[4:0]);
      mPc  = mLink[b];
      mStat = mSaved[b];
      nPcL = 1'b1;
      ev   = "R9";
    end else if (wr) begin
      mStat = wv;
      ev    = "R10";
    end
    mPcL = nPcL;
    mFl  = nFl;
  endtask

  task automatic doCycle(string tag, logic [7:0] req, logic ret, logic wr,
                         logic [31:0] wv, logic [31:0] pc);
    string ev;
    string t;
    rstReq = req[0]; undefReq = req[1]; swiReq = req[2]; pabtReq = req[3];
    dabtReq = req[4]; irqReq = req[6]; fiqReq = req[7];
    retReq = ret; statusWr = wr; statusIn = wv; pcNow = pc;
    modelStep(req, ret, wr, wv, pc, ev);
    @(negedge clk);
    t = (tag == "") ? ev : tag;
    compareAll(t);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) doCycle("", 8'h00, 1'b0, 1'b0, 32'h0, 32'h0);
  endtask

  task automatic setStatus(logic [31:0] v);
    doCycle("R10", 8'h00, 1'b0, 1'b1, v, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0;
    {rstReq, undefReq, swiReq, pabtReq, dabtReq, irqReq, fiqReq, retReq, statusWr} = '0;
    statusIn = '0; pcNow = '0;
    mStat = 32'h0000_00D3; mPc = '0; mPcL = 1'b0; mFl = 1'b0;
    for (int i = 0; i < 5; i++) begin mSaved[i] = '0; mLink[i] = '0; end
    repeat (3) @(negedge clk);
    compareAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");

    // R2 R3: each exception from user mode, interrupts unmasked
    for (int k = 0; k < 8; k++) begin
      if (k == 5) continue;
      setStatus(32'hA000_0010);
      doCycle("R2 R3", 8'(1) << k, 1'b0, 1'b0, 32'h0, 32'h0000_1008 + 32'(k) * 32'h100);
      doCycle("R8", 8'h00, 1'b0, 1'b0, 32'h0, 32'h0);
      idle(1);
    end

    // R4: simultaneous requests, each step removes the previous winner
    begin
      logic [7:0] pend [7] = '{8'hDF, 8'hDE, 8'hCE, 8'h4E, 8'h0E, 8'h06, 8'h04};
      for (int i = 0; i < 7; i++) begin
        setStatus(32'h0000_0010);
        doCycle("R4", pend[i], 1'b0, 1'b0, 32'h0, 32'h0000_2000);
        idle(2);
      end
    end

    // R6: masked interrupts ignored
    setStatus(32'h0000_0090);
    doCycle("R6", 8'h40, 1'b0, 1'b0, 32'h0, 32'h3000);
    setStatus(32'h0000_0050);
    doCycle("R6", 8'h80, 1'b0, 1'b0, 32'h0, 32'h3000);
    setStatus(32'h0000_00D0);
    doCycle("R6", 8'hC0, 1'b0, 1'b0, 32'h0, 32'h3000);

    // R8: requests during load and flush cycles ignored
    setStatus(32'h0000_0010);
    doCycle("R8", 8'h04, 1'b0, 1'b0, 32'h0, 32'h4000);
    doCycle("R8", 8'h10, 1'b1, 1'b0, 32'h0, 32'h4100);
    doCycle("R8", 8'h01, 1'b1, 1'b0, 32'h0, 32'h4200);
    // R9: return from supervisor back to user
    doCycle("R9", 8'h00, 1'b1, 1'b0, 32'h0, 32'h0);
    idle(2);
    doCycle("R9", 8'h00, 1'b1, 1'b0, 32'h0, 32'h0);
    setStatus(32'h0000_001F);
    doCycle("R9", 8'h00, 1'b1, 1'b0, 32'h0, 32'h0);
    // R9: entry beats return
    setStatus(32'h0000_0013);
    doCycle("R9", 8'h02, 1'b1, 1'b0, 32'h0, 32'h5000);
    idle(2);

    // R11: bank view follows mode written directly
    setStatus(32'h0000_0011);
    doCycle("R11", 8'h00, 1'b0, 1'b0, 32'h0, 32'h0);
    setStatus(32'h0000_0010);
    doCycle("R11", 8'h00, 1'b0, 1'b0, 32'h0, 32'h0);

    // Random mix
    for (int n = 0; n < RAND_CYCLES; n++) begin
      logic [7:0] req;
      logic ret, wr;
      logic [31:0] wv;
      req = '0;
      for (int k = 0; k < 8; k++)
        if (k != 5 && $urandom_range(0, 99) < 6) req[k] = 1'b1;
      if ($urandom_range(0, 99) < 70) req[0] = 1'b0;
      ret = ($urandom_range(0, 99) < 15);
      wr  = ($urandom_range(0, 99) < 12);
      wv  = {$urandom_range(0, 15), 20'h0, 2'(($urandom_range(0, 3))), 1'b0, randMode()};
      doCycle("", req, ret, wr, wv, {$urandom_range(0, 32'h3FFF_FFFF), 2'b00});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule